// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block joins two eight-input priority interrupt controllers into one sixteen-line interrupt system with a single interrupt output and a single vector handshake towards the processor. The first controller (the primary) takes lines 0 to 7. The second controller (the secondary) takes lines 8 to 15 and reaches the processor through the primary's input 2. Input 2 is therefore not a device line: when it wins arbitration on the primary, the secondary's own resolver supplies the vector.

Each controller has two byte registers on a simple read/write strobe bus: a command port and a data port. Through these, software sets the vector base, the enable mask, the read-back selection and the end-of-interrupt behaviour. The processor sees `int_out` and the vector on `int_vec`. It pulses `int_ack` in a cycle where `int_out` is high to take that vector, and the block then updates its pending and in-service state.

Top module: `pic_cascade_pair`

## Requirements
- R1: The primary decodes bus addresses 0x20 (command port, address bit 0 = 0) and 0x21 (data port, bit 0 = 1). The secondary decodes 0xA0 and 0xA1. Writes to any other address change nothing, and reads from any other address return 0x00.
- R2: A command write with bit 4 set starts setup and records bit 0 as "configuration word follows". The next data write sets the vector base. The data write after that is consumed with no effect. If the flag was set, the next data write sets auto end-of-interrupt from its bit 1 (1 = on). Any other data write sets the mask, where bit n = 1 disables line n. A data-port read returns the mask.
- R3: A command write with bits [4:3] = 01 selects what a command-port read returns: bit 0 = 1 gives the pending register, bit 0 = 0 gives the in-service register.
- R4: After reset every line is masked (a data read gives 0xFF), the vector base is 0x00, auto end-of-interrupt is on, pending and in-service are zero, command reads return pending, and `int_out` is low.
- R5: A one-cycle pulse on line n < 8 sets primary pending bit n. A pulse on line n >= 8 sets secondary pending bit n-8 and also sets primary pending bit 2. A request set in the same cycle as any clear of that bit wins.
- R6: Within a controller, the lowest-numbered pending and enabled line wins. Its vector is the base OR the line index.
- R7: When the primary's winner is line 2, or when the primary has no enabled pending line, the secondary's winner supplies `int_vec`. Only one vector is offered at a time.
- R8: A controller whose in-service register holds a bit with index at or below its winner offers nothing. A blocked primary also hides the secondary path, so `int_out` is low.
- R9: `int_ack` while `int_out` is high clears the winning pending bit. It sets the matching in-service bit only when auto end-of-interrupt is off. When the secondary supplies the vector, the primary clears its bit 2 and sets no in-service bit. `int_ack` while `int_out` is low has no effect.
- R10: After the secondary delivers a vector, if any other secondary pending bit remains, primary pending bit 2 is set again.
- R11: A command write with bits [4:3] = 00 and bits [7:5] = 001 clears the lowest set in-service bit. With bits [7:5] = 011 it clears in-service bit [2:0]. Other codes leave the in-service register unchanged.
- R12: When the primary's winner is line 2 but the secondary cannot offer a vector, primary pending bit 2 is cleared on the next edge with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_line | input | 16 | One-cycle request pulses for lines 0 to 15 |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, valid in the cycle of `bus_rd` |
| int_out | output | 1 | Interrupt offered to the processor |
| int_ack | input | 1 | Processor takes the offered vector |
| int_vec | output | 8 | Offered vector, 0x00 when nothing is offered |

## Verification
A wrong pending, in-service or mask bit shows up on `int_out` and `int_vec` in the very next cycle, because both are combinational views of the registers. The primary's cascade bit is the hardest state to observe: a lost re-raise or a stale cascade bit only shows when a lower-priority primary line is overtaken or a remaining secondary request goes missing. The bench therefore reads the primary pending register in the cycles just after a secondary acknowledge. A reference model tracks every register every cycle, so a divergence in any part of the state is reported on the first cycle it reaches a port.

// File: rtl/pic_pair_pkg.sv
package pic_pair_pkg;

  // command-port classes, picked by bits [4:3] of the written byte
  localparam int CMD_SETUP_BIT = 4;
  localparam int CMD_RSEL_BIT  = 3;

  // end-of-interrupt codes in bits [7:5]
  localparam logic [2:0] EOI_LOWEST  = 3'b001;
  localparam logic [2:0] EOI_INDEXED = 3'b011;

  // setup sequencing after a setup command
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_WANT_BASE = 2'd1,
    PH_WANT_CASC = 2'd2
  } setup_phase_t;

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);

  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = i[W-1:0];
    end
  end

endmodule

// File: rtl/pic_ctrl_core.sv
module pic_ctrl_core
  import pic_pair_pkg::*;
#(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_cmd,
  input  logic         wr_data,
  input  logic [7:0]   wdata,
  input  logic [N-1:0] req_set,
  input  logic [N-1:0] drop_mask,
  input  logic         take,
  input  logic         no_isr,
  output logic         any_pend,
  output logic         ok,
  output logic [W-1:0] win_idx,
  output logic [7:0]   vector,
  output logic         rest_pend,
  output logic [N-1:0] pend_q,
  output logic [7:0]   cmd_rdata,
  output logic [7:0]   data_rdata
);

  logic [N-1:0] irr_q, irr_d;
  logic [N-1:0] isr_q, isr_d;
  logic [N-1:0] enb_q, enb_d;
  logic [7:0]   base_q, base_d;
  logic         aeoi_q, aeoi_d;
  logic         x4_q, x4_d;
  logic         rdirr_q, rdirr_d;
  setup_phase_t phase_q, phase_d;

  logic         cfg_en;
  logic [N-1:0] en_pend;
  logic         svc_any;
  logic [W-1:0] svc_idx;
  logic         blocked;
  logic [N-1:0] win_bit, svc_bit;
  logic         is_setup, is_rsel, is_eoi;
  logic [2:0]   eoi_code;
  logic [N-1:0] eoi_clr, take_clr, isr_set;

  assign en_pend = irr_q & enb_q;

  pic_prio_find #(.N(N)) u_win (
    .vec   (en_pend),
    .found (any_pend),
    .idx   (win_idx)
  );

  pic_prio_find #(.N(N)) u_svc (
    .vec   (isr_q),
    .found (svc_any),
    .idx   (svc_idx)
  );

  assign blocked   = svc_any && (svc_idx <= win_idx);
  assign ok        = any_pend && !blocked;
  assign win_bit   = N'(1) << win_idx;
  assign svc_bit   = N'(1) << svc_idx;
  assign rest_pend = |(irr_q & ~win_bit);
  assign vector    = base_q | {{(8 - W){1'b0}}, win_idx};
  assign pend_q    = irr_q;

  // command decode
  assign is_setup = wdata[CMD_SETUP_BIT];
  assign is_rsel  = !wdata[CMD_SETUP_BIT] && wdata[CMD_RSEL_BIT];
  assign is_eoi   = !wdata[CMD_SETUP_BIT] && !wdata[CMD_RSEL_BIT];
  assign eoi_code = wdata[7:5];

  always_comb begin
    eoi_clr = '0;
    if (wr_cmd && is_eoi) begin
      if (eoi_code == EOI_LOWEST)       eoi_clr = svc_any ? svc_bit : '0;
      else if (eoi_code == EOI_INDEXED) eoi_clr = N'(1) << wdata[W-1:0];
    end
  end

  assign take_clr = take ? win_bit : '0;
  assign isr_set  = (take && !no_isr && !aeoi_q) ? win_bit : '0;

  // next state: pending and in-service
  always_comb begin
    irr_d = (irr_q & ~take_clr & ~drop_mask) | req_set;
    isr_d = (isr_q & ~eoi_clr) | isr_set;
  end

  // next state: configuration
  always_comb begin
    base_d  = base_q;
    enb_d   = enb_q;
    aeoi_d  = aeoi_q;
    x4_d    = x4_q;
    rdirr_d = rdirr_q;
    phase_d = phase_q;
    if (wr_cmd && is_setup) begin
      x4_d    = wdata[0];
      phase_d = PH_WANT_BASE;
    end else if (wr_cmd && is_rsel) begin
      rdirr_d = wdata[0];
    end else if (wr_data) begin
      case (phase_q)
        PH_WANT_BASE: begin
          base_d  = wdata;
          phase_d = PH_WANT_CASC;
        end
        PH_WANT_CASC: phase_d = PH_IDLE;
        default: begin
          if (x4_q) begin
            aeoi_d = wdata[1];
            x4_d   = 1'b0;
          end else begin
            enb_d = ~wdata[N-1:0];
          end
        end
      endcase
    end
  end

  assign cfg_en = wr_cmd || wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      enb_q   <= '0;
      aeoi_q  <= 1'b1;
      x4_q    <= 1'b0;
      rdirr_q <= 1'b1;
      phase_q <= PH_IDLE;
    end else if (cfg_en) begin
      base_q  <= base_d;
      enb_q   <= enb_d;
      aeoi_q  <= aeoi_d;
      x4_q    <= x4_d;
      rdirr_q <= rdirr_d;
      phase_q <= phase_d;
    end
  end

  assign cmd_rdata  = 8'(rdirr_q ? irr_q : isr_q);
  assign data_rdata = 8'(~enb_q);

  // R9
  take_needs_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ok);

  // R9
  take_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (req_set == '0) |=> irr_q[$past(win_idx)] == 1'b0);

  // R11
  eoi_indexed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && (wdata[4:3] == 2'b00) && (wdata[7:5] == EOI_INDEXED) && !take
    |=> !isr_q[$past(wdata[W-1:0])]);

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && (phase_q == PH_IDLE) && !x4_q |=> data_rdata == $past(wdata));

endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair #(
  parameter int              CTRL_IN     = 8,
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] MASTER_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] SLAVE_BASE  = 8'hA0,
  parameter int              CASC_IN     = 2,
  localparam int             LINES       = 2 * CTRL_IN,
  localparam int             W           = $clog2(CTRL_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_line,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              int_out,
  input  logic              int_ack,
  output logic [7:0]        int_vec
);

  localparam int PRI = 0;
  localparam int SEC = 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [1:0]                 c_sel, c_wr_cmd, c_wr_data;
  logic [1:0]                 c_any, c_ok, c_rest, c_take, c_noisr;
  logic [1:0][CTRL_IN-1:0]    c_req, c_drop, c_pend;
  logic [1:0][W-1:0]          c_win;
  logic [1:0][7:0]            c_vec, c_cmd_rd, c_data_rd;

  logic pri_on_casc, use_pri, use_sec, take, reraise, stale_drop, sec_lines;

  for (genvar g = 0; g < 2; g++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_BASE = (g == PRI) ? MASTER_BASE : SLAVE_BASE;

    assign c_sel[g]     = bus_addr[ADDR_W-1:1] == MY_BASE[ADDR_W-1:1];
    assign c_wr_cmd[g]  = bus_wr && c_sel[g] && !bus_addr[0];
    assign c_wr_data[g] = bus_wr && c_sel[g] &&  bus_addr[0];

    pic_ctrl_core #(.N(CTRL_IN)) u_core (
      .clk        (clk),
      .rst_n      (rst_q),
      .wr_cmd     (c_wr_cmd[g]),
      .wr_data    (c_wr_data[g]),
      .wdata      (bus_wdata),
      .req_set    (c_req[g]),
      .drop_mask  (c_drop[g]),
      .take       (c_take[g]),
      .no_isr     (c_noisr[g]),
      .any_pend   (c_any[g]),
      .ok         (c_ok[g]),
      .win_idx    (c_win[g]),
      .vector     (c_vec[g]),
      .rest_pend  (c_rest[g]),
      .pend_q     (c_pend[g]),
      .cmd_rdata  (c_cmd_rd[g]),
      .data_rdata (c_data_rd[g])
    );
  end

  // cascade resolution
  assign pri_on_casc = c_any[PRI] && (c_win[PRI] == W'(CASC_IN));
  assign use_pri     = c_ok[PRI] && !pri_on_casc;
  assign use_sec     = c_any[PRI] ? (c_ok[PRI] && pri_on_casc && c_ok[SEC]) : c_ok[SEC];
  assign stale_drop  = c_ok[PRI] && pri_on_casc && !c_ok[SEC];
  assign take        = int_ack && int_out;
  assign reraise     = c_take[SEC] && c_rest[SEC];
  assign sec_lines   = |irq_line[LINES-1:CTRL_IN];

  assign int_out = use_pri || use_sec;
  assign int_vec = use_pri ? c_vec[PRI] : (use_sec ? c_vec[SEC] : 8'h00);

  always_comb begin
    c_take[PRI]  = take && (use_pri || (use_sec && c_any[PRI]));
    c_take[SEC]  = take && use_sec;
    c_noisr[PRI] = use_sec;
    c_noisr[SEC] = 1'b0;
    c_drop[PRI]  = stale_drop ? (CTRL_IN'(1) << CASC_IN) : '0;
    c_drop[SEC]  = '0;
    c_req[PRI]   = irq_line[CTRL_IN-1:0]
                 | ((sec_lines || reraise) ? (CTRL_IN'(1) << CASC_IN) : '0);
    c_req[SEC]   = irq_line[LINES-1:CTRL_IN];
  end

  // register read-back
  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (c_sel[PRI])      bus_rdata = bus_addr[0] ? c_data_rd[PRI] : c_cmd_rd[PRI];
      else if (c_sel[SEC]) bus_rdata = bus_addr[0] ? c_data_rd[SEC] : c_cmd_rd[SEC];
    end
  end

  // R10
  reraise_casc_chk: assert property (@(posedge clk) disable iff (!rst_q)
    c_take[SEC] && c_rest[SEC] |=> c_pend[PRI][CASC_IN]);

  // R12
  stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    stale_drop && !irq_line[CASC_IN] && !sec_lines |=> !c_pend[PRI][CASC_IN]);

  // R8
  blocked_pri_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    c_any[PRI] && !c_ok[PRI] |-> !int_out);

  // R7
  casc_never_vector_chk: assert property (@(posedge clk) disable iff (!rst_q)
    use_pri |-> c_win[PRI] != W'(CASC_IN));

  // R5
  sec_route_chk: assert property (@(posedge clk) disable iff (!rst_q)
    sec_lines |=> (c_pend[SEC] != '0) && c_pend[PRI][CASC_IN]);

endmodule

// File: tb/test_pic_cascade_pair.sv
module test_pic_cascade_pair;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_line;
  logic [7:0]  bus_addr, bus_wdata;
  logic        bus_wr, bus_rd, int_ack;
  logic [7:0]  bus_rdata, int_vec;
  logic        int_out;

  always #4 clk = ~clk;  // 125 MHz

  pic_cascade_pair i_pic_cascade_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_line  (irq_line),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .int_out   (int_out),
    .int_ack   (int_ack),
    .int_vec   (int_vec)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state, index 0 = primary, 1 = secondary
  logic [7:0] mo_irr[2], mo_isr[2], mo_enb[2], mo_base[2];
  bit         mo_ae[2], mo_x4[2], mo_rdirr[2];
  int         mo_ph[2];

  function automatic int lowest(input logic [7:0] x);
    for (int i = 0; i < 8; i++) if (x[i]) return i;
    return 8;
  endfunction

  task automatic chk8(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      mo_irr[c] = 0; mo_isr[c] = 0; mo_enb[c] = 0; mo_base[c] = 0;
      mo_ae[c] = 1; mo_x4[c] = 0; mo_rdirr[c] = 1; mo_ph[c] = 0;
    end
  endtask

  // one bus/interrupt cycle: drive, compare against the model, advance the model
  task automatic cyc(input logic [15:0] ln, input bit wr, input bit rd,
                     input logic [7:0] ad, input logic [7:0] wd, input bit ak,
                     input string tag, output logic [7:0] rd_seen);
    bit any[2], ok[2];
    int w[2];
    bit um, us, mi, drop, take;
    logic [7:0] ev, er;
    logic [7:0] ci[2], si[2], cr[2], sr[2];
    int c;
    @(negedge clk);
    irq_line = ln; bus_wr = wr; bus_rd = rd; bus_addr = ad; bus_wdata = wd; int_ack = ak;
    #1;
    for (int k = 0; k < 2; k++) begin
      any[k] = (mo_irr[k] & mo_enb[k]) != 0;
      w[k]   = lowest(mo_irr[k] & mo_enb[k]);
      ok[k]  = any[k] && !(mo_isr[k] != 0 && lowest(mo_isr[k]) <= w[k]);
    end
    um   = ok[0] && w[0] != 2;
    us   = !any[0] ? ok[1] : (ok[0] && w[0] == 2 && ok[1]);
    mi   = um || us;
    drop = ok[0] && w[0] == 2 && !ok[1];
    ev   = um ? (mo_base[0] | 8'(w[0])) : (us ? (mo_base[1] | 8'(w[1])) : 8'h00);
    c    = (ad[7:1] == 7'h10) ? 0 : ((ad[7:1] == 7'h50) ? 1 : -1);
    er   = 8'h00;
    if (rd && c >= 0) er = ad[0] ? ~mo_enb[c] : (mo_rdirr[c] ? mo_irr[c] : mo_isr[c]);
    chk8({7'd0, int_out}, {7'd0, mi}, {tag, " int_out"});
    chk8(int_vec, ev, {tag, " int_vec"});
    chk8(bus_rdata, er, {tag, " bus_rdata"});
    rd_seen = bus_rdata;
    // next state
    for (int k = 0; k < 2; k++) begin ci[k] = 0; si[k] = 0; cr[k] = 0; sr[k] = 0; end
    take = ak && mi;
    if (take && (um || (us && any[0]))) begin
      cr[0][w[0]] = 1'b1;
      if (um && !mo_ae[0]) si[0][w[0]] = 1'b1;
    end
    if (drop) cr[0][2] = 1'b1;
    if (take && us) begin
      cr[1][w[1]] = 1'b1;
      if (!mo_ae[1]) si[1][w[1]] = 1'b1;
      if ((mo_irr[1] & ~(8'd1 << w[1])) != 0) sr[0][2] = 1'b1;
    end
    sr[0] = sr[0] | ln[7:0];
    if (ln[15:8] != 0) sr[0][2] = 1'b1;
    sr[1] = sr[1] | ln[15:8];
    if (wr && c >= 0) begin
      if (!ad[0]) begin
        if (wd[4]) begin mo_x4[c] = wd[0]; mo_ph[c] = 1; end
        else if (wd[3]) mo_rdirr[c] = wd[0];
        else if (wd[7:5] == 3'b001) ci[c] = mo_isr[c] & (~mo_isr[c] + 8'd1);
        else if (wd[7:5] == 3'b011) ci[c] = 8'd1 << wd[2:0];
      end else begin
        if (mo_ph[c] == 1) begin mo_base[c] = wd; mo_ph[c] = 2; end
        else if (mo_ph[c] == 2) mo_ph[c] = 0;
        else if (mo_x4[c]) begin mo_ae[c] = wd[1]; mo_x4[c] = 0; end
        else mo_enb[c] = ~wd;
      end
    end
    for (int k = 0; k < 2; k++) begin
      mo_irr[k] = (mo_irr[k] & ~cr[k]) | sr[k];
      mo_isr[k] = (mo_isr[k] & ~ci[k]) | si[k];
    end
    @(posedge clk);
  endtask

  logic [7:0] rv;

  task automatic wr8(input logic [7:0] ad, input logic [7:0] d, input string tag);
    cyc(16'h0, 1, 0, ad, d, 0, tag, rv);
  endtask
  task automatic rd8(input logic [7:0] ad, input logic [7:0] exp, input string tag);
    cyc(16'h0, 0, 1, ad, 8'h00, 0, tag, rv);
    chk8(rv, exp, tag);
  endtask
  task automatic req(input logic [15:0] ln, input string tag);
    cyc(ln, 0, 0, 8'h00, 8'h00, 0, tag, rv);
  endtask
  task automatic ack(input string tag);
    cyc(16'h0, 0, 0, 8'h00, 8'h00, 1, tag, rv);
  endtask
  task automatic expect_int(input bit i, input logic [7:0] v, input string tag);
    #1;
    chk8({7'd0, int_out}, {7'd0, i}, {tag, " offer"});
    chk8(int_vec, v, {tag, " vector"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    irq_line = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; int_ack = 0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R4: reset state
    expect_int(0, 8'h00, "R4");
    rd8(8'h21, 8'hFF, "R4 primary mask");
    rd8(8'hA1, 8'hFF, "R4 secondary mask");
    rd8(8'h20, 8'h00, "R4 primary pending");
    req(16'h0020, "R4 masked line");
    expect_int(0, 8'h00, "R4 masked");

    // R2: setup with configuration word, auto end-of-interrupt off
    wr8(8'h20, 8'h11, "R2"); wr8(8'h21, 8'h08, "R2"); wr8(8'h21, 8'h04, "R2");
    wr8(8'h21, 8'h01, "R2"); wr8(8'h21, 8'h00, "R2");
    wr8(8'hA0, 8'h11, "R2"); wr8(8'hA1, 8'h70, "R2"); wr8(8'hA1, 8'h02, "R2");
    wr8(8'hA1, 8'h01, "R2"); wr8(8'hA1, 8'h00, "R2");
    rd8(8'h21, 8'h00, "R2 mask readback");

    // R6: line 5 left from reset plus line 3
    req(16'h0008, "R6");
    expect_int(1, 8'h0B, "R6 lowest wins");
    ack("R9");
    expect_int(0, 8'h00, "R8 blocked by in-service 3");
    rd8(8'h20, 8'h20, "R3 pending view");
    wr8(8'h20, 8'h0A, "R3");
    rd8(8'h20, 8'h08, "R3 in-service view");
    wr8(8'h20, 8'h40, "R11 unknown code");
    rd8(8'h20, 8'h08, "R11 unknown code no effect");
    wr8(8'h20, 8'h20, "R11 lowest");
    expect_int(1, 8'h0D, "R11 after lowest eoi");
    ack("R9");
    wr8(8'h20, 8'h65, "R11 indexed");
    rd8(8'h20, 8'h00, "R11 indexed cleared");
    wr8(8'h20, 8'h0B, "R3");

    // R5 R7 R10 R12: two secondary lines
    req(16'h1200, "R5");
    expect_int(1, 8'h71, "R7 secondary vector");
    ack("R10");
    rd8(8'h20, 8'h04, "R10 cascade re-raised");
    rd8(8'h20, 8'h00, "R12 stale cascade dropped");
    expect_int(0, 8'h00, "R8 secondary blocked");
    wr8(8'hA0, 8'h20, "R11 secondary");
    expect_int(1, 8'h74, "R7 direct consult");
    ack("R9");
    wr8(8'hA0, 8'h20, "R11 secondary");

    // R7: primary line 6 and secondary line 10 together
    req(16'h0440, "R7");
    expect_int(1, 8'h72, "R7 cascade beats 6");
    ack("R9");
    expect_int(1, 8'h0E, "R9 no primary in-service for cascade");
    ack("R9");
    expect_int(0, 8'h00, "R9");
    cyc(16'h0, 0, 0, 8'h00, 8'h00, 1, "R9 ignored ack", rv);
    expect_int(0, 8'h00, "R9 ignored ack");
    wr8(8'h20, 8'h20, "R11"); wr8(8'hA0, 8'h20, "R11");

    // R2 masking, R1 decode
    wr8(8'h21, 8'h08, "R2 mask 3");
    req(16'h0008, "R2");
    expect_int(0, 8'h00, "R2 masked line");
    rd8(8'h21, 8'h08, "R2 mask read");
    wr8(8'h23, 8'hFF, "R1 foreign address");
    wr8(8'h61, 8'hFF, "R1 foreign address");
    rd8(8'h21, 8'h08, "R1 mask untouched");
    rd8(8'h30, 8'h00, "R1 foreign read");
    wr8(8'h21, 8'h00, "R2 unmask");
    expect_int(1, 8'h0B, "R2 unmasked line");
    ack("R9");
    wr8(8'h20, 8'h20, "R11");

    // R9: secondary with auto end-of-interrupt on
    wr8(8'hA0, 8'h11, "R2"); wr8(8'hA1, 8'h70, "R2"); wr8(8'hA1, 8'h02, "R2");
    wr8(8'hA1, 8'h03, "R2");
    req(16'h0100, "R9");
    expect_int(1, 8'h70, "R9 auto eoi vector");
    ack("R9");
    wr8(8'hA0, 8'h0A, "R3");
    rd8(8'hA0, 8'h00, "R9 auto eoi leaves in-service clear");

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ln;
      logic [7:0]  ad, d;
      bit          wr, rd, ak;
      int          r;
      ln = ($urandom_range(0, 5) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
      ak = $urandom_range(0, 2) == 0;
      wr = 0; rd = 0; d = 0;
      r  = $urandom_range(0, 9);
      ad = ($urandom_range(0, 1) == 0) ? 8'h20 : 8'hA0;
      case (r)
        0: begin wr = 1; d = 8'h20; end
        1: begin wr = 1; d = 8'h60 | 8'($urandom_range(0, 7)); end
        2: begin wr = 1; d = 8'h0A | 8'($urandom_range(0, 1)); end
        3: begin wr = 1; ad[0] = 1; d = 8'($urandom_range(0, 255)) & 8'h3C; end
        4: begin rd = 1; ad[0] = 1'($urandom_range(0, 1)); end
        5: begin wr = 1; ad = 8'($urandom_range(0, 255)); d = 8'($urandom_range(0, 255)); end
        default: ;
      endcase
      cyc(ln, wr, rd, ad, d, ak, "R5 R6 R7 R8 random", rv);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule